// File: doc/BRIEF.md
# Privileged Instruction Permission Gate

This block decides, in a single combinational pass, whether a privileged system instruction may run, must raise an illegal-instruction exception, or must raise a virtual-instruction exception. It covers wait-for-interrupt, the wait-on-reservation-set variant without a timeout, the supervisor address-translation fence, the two hypervisor address-translation fences (guest-virtual and guest-physical), and the hypervisor guest-memory load, store and execute-type load.

The decision depends on the current privilege level, on whether the hart is running a virtualized guest, on whether supervisor mode is implemented, and on a handful of trap-enable bits. These are the timeout-wait and translation-trap bits from the machine status register, plus the virtual timeout-wait, virtual translation-trap and user-hypervisor-access bits from the hypervisor status register. For guest-memory instructions the block also produces the translation-context index that the memory pipeline uses for a two-stage access. Carrying out the halt, the flush or the memory access is left to the surrounding pipeline.

Top module: `priv_op_gate`

## Requirements
- R1: Opcode 0 (wait-for-interrupt) gives illegal (verdict 1) in supervisor mode with timeout-wait set, in user mode with timeout-wait set when supervisor mode is absent, and in non-virtualized user mode when supervisor mode exists. Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R2: When R1 does not apply, opcode 0 gives virtual (verdict 2) when virtualized in user mode, or in supervisor mode with virtual timeout-wait set. In every other case it gives allow (verdict 0).
- R3: Opcode 1 (reservation wait, no timeout) gives virtual when virtualized in user or supervisor mode with virtual timeout-wait set and timeout-wait clear. Otherwise it gives illegal outside machine mode with timeout-wait set, and allow in every other case.
- R4: Opcode 2 (supervisor fence) gives illegal when not virtualized and either in user mode, or in supervisor mode with translation-trap set. When virtualized, it gives virtual in user mode or with virtual translation-trap set. It gives allow otherwise.
- R5: Opcode 3 (guest-virtual hypervisor fence) gives virtual whenever virtualized. Otherwise it gives allow in machine or supervisor mode, and illegal in user mode.
- R6: Opcode 4 (guest-physical hypervisor fence) behaves as R5, except that it gives illegal in non-virtualized supervisor mode with translation-trap set.
- R7: Opcodes 5, 6 and 7 (guest load, guest store, guest execute-type load) give allow in machine mode. Otherwise they give virtual when virtualized, illegal in user mode with user-hypervisor-access clear, and allow in every other case.
- R8: For opcodes 5 to 7 the context output has bit 3 (two-stage flag) set. Its low bits hold the mode from the previous-virtual-privilege input (0 user, 1 supervisor), replaced by index 2 when the opcode is not 7, that mode is supervisor and the guest SUM bit is set. The context output does not depend on the verdict.
- R9: For opcodes 0 to 4 the context output is zero.
- R10: When the illegal and virtual conditions of opcode 0 hold together, illegal is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Instruction selector (0 wait, 1 reservation wait, 2 supervisor fence, 3 guest-virtual fence, 4 guest-physical fence, 5 guest load, 6 guest store, 7 guest execute-type load) |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Hart is running a virtualized guest |
| has_smode_i | input | 1 | Supervisor mode is implemented |
| mst_tw_i | input | 1 | Machine status timeout-wait bit |
| mst_tvm_i | input | 1 | Machine status translation-trap bit |
| hst_vtw_i | input | 1 | Hypervisor status virtual timeout-wait bit |
| hst_vtvm_i | input | 1 | Hypervisor status virtual translation-trap bit |
| hst_hu_i | input | 1 | Hypervisor status user-hypervisor-access bit |
| hst_spvp_i | input | 1 | Hypervisor status previous-virtual-privilege bit |
| vs_sum_i | input | 1 | Guest supervisor status SUM bit |
| verdict_o | output | 2 | 0 allow, 1 illegal instruction, 2 virtual instruction |
| ctx_o | output | 4 | Two-stage translation context index |

## Verification
The bench builds the block with its default parameters: a 4-bit context, the two-stage flag at bit 3 and the supervisor-with-SUM index at 2. These values fix the context codes 8, 9 and 10 that the vectors expect. This brings every opcode and every privilege level the encoding allows within reach, including the crossings where two rules compete. These include the wait instruction with both timeout bits set, the guest-physical fence with translation-trap set under and outside virtualization, and machine mode with user-hypervisor-access clear. The execute-type load is exercised against the SUM substitution.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

   typedef enum logic [1:0] {
      PL_USER  = 2'd0,
      PL_SUPER = 2'd1,
      PL_MACH  = 2'd3
   } plevel_e;

   typedef enum logic [1:0] {
      VD_ALLOW   = 2'd0,
      VD_ILLEGAL = 2'd1,
      VD_VIRTUAL = 2'd2
   } verdict_e;

   typedef enum logic [2:0] {
      OP_WAIT     = 3'd0,
      OP_RSV_WAIT = 3'd1,
      OP_SFENCE   = 3'd2,
      OP_HF_GVIRT = 3'd3,
      OP_HF_GPHYS = 3'd4,
      OP_G_LOAD   = 3'd5,
      OP_G_STORE  = 3'd6,
      OP_G_XLOAD  = 3'd7
   } gate_op_e;

   typedef struct packed {
      logic       virt;
      logic       has_smode;
      logic       tw;
      logic       tvm;
      logic       vtw;
      logic       vtvm;
      logic       hu;
   } gate_ctl_t;

endpackage

// File: rtl/wait_rules.sv
module wait_rules
   import priv_gate_pkg::*;
(
   input  logic [1:0] priv_i,
   input  gate_ctl_t  ctl_i,
   output logic [1:0] wait_vd_o,
   output logic [1:0] rsv_vd_o
);
   logic is_u, is_s, is_m;
   logic wait_ill, wait_virt;
   logic rsv_virt, rsv_ill;

   assign is_u = (priv_i == PL_USER);
   assign is_s = (priv_i == PL_SUPER);
   assign is_m = (priv_i == PL_MACH);

   // Wait-for-interrupt: illegal conditions are tested first.
   always_comb begin
      wait_ill  = (is_s && ctl_i.tw)
                | (is_u && !ctl_i.has_smode && ctl_i.tw)
                | (is_u && ctl_i.has_smode && !ctl_i.virt);
      wait_virt = ctl_i.virt && (is_u || (is_s && ctl_i.vtw));
      if (wait_ill)       wait_vd_o = VD_ILLEGAL;
      else if (wait_virt) wait_vd_o = VD_VIRTUAL;
      else                wait_vd_o = VD_ALLOW;
   end

   // Reservation wait: the virtual condition is tested first.
   always_comb begin
      rsv_virt = ctl_i.virt && (is_s || is_u) && ctl_i.vtw && !ctl_i.tw;
      rsv_ill  = !is_m && ctl_i.tw;
      if (rsv_virt)     rsv_vd_o = VD_VIRTUAL;
      else if (rsv_ill) rsv_vd_o = VD_ILLEGAL;
      else              rsv_vd_o = VD_ALLOW;
   end

   always_comb begin
      if (!$isunknown({priv_i, ctl_i})) begin
         if (is_s && ctl_i.tw && ctl_i.virt && ctl_i.vtw)
            assert_wait_ill_first_R10: assert (wait_vd_o == VD_ILLEGAL)
               else $error("wait: illegal must win over virtual");
         if (is_m)
            assert_rsv_mach_allow_R3: assert (rsv_vd_o == VD_ALLOW)
               else $error("reservation wait faulted in machine mode");
      end
   end

endmodule

// File: rtl/fence_rules.sv
module fence_rules
   import priv_gate_pkg::*;
(
   input  logic [1:0] priv_i,
   input  gate_ctl_t  ctl_i,
   output logic [1:0] sf_vd_o,
   output logic [1:0] hfv_vd_o,
   output logic [1:0] hfp_vd_o
);
   logic is_u, is_s, is_m;
   logic hf_ok;

   assign is_u = (priv_i == PL_USER);
   assign is_s = (priv_i == PL_SUPER);
   assign is_m = (priv_i == PL_MACH);

   always_comb begin
      if (!ctl_i.virt && (is_u || (is_s && ctl_i.tvm)))
         sf_vd_o = VD_ILLEGAL;
      else if (ctl_i.virt && (is_u || ctl_i.vtvm))
         sf_vd_o = VD_VIRTUAL;
      else
         sf_vd_o = VD_ALLOW;
   end

   assign hf_ok = is_m || (is_s && !ctl_i.virt);

   always_comb begin
      if (ctl_i.virt)  hfv_vd_o = VD_VIRTUAL;
      else if (hf_ok)  hfv_vd_o = VD_ALLOW;
      else             hfv_vd_o = VD_ILLEGAL;
   end

   // Guest-physical fence adds a translation-trap check ahead of the
   // common hypervisor fence rule.
   always_comb begin
      if (is_s && !ctl_i.virt && ctl_i.tvm) hfp_vd_o = VD_ILLEGAL;
      else                                   hfp_vd_o = hfv_vd_o;
   end

   always_comb begin
      if (!$isunknown({priv_i, ctl_i})) begin
         if (ctl_i.virt)
            assert_hfence_virt_R5: assert (hfv_vd_o == VD_VIRTUAL && hfp_vd_o == VD_VIRTUAL)
               else $error("hypervisor fence not virtual under virtualization");
         if (is_m)
            assert_sfence_mach_R4: assert (sf_vd_o != VD_ILLEGAL)
               else $error("supervisor fence illegal in machine mode");
         if (is_s && !ctl_i.virt && !ctl_i.tvm)
            assert_gphys_sup_R6: assert (hfp_vd_o == VD_ALLOW)
               else $error("guest-physical fence blocked without trap bit");
      end
   end

endmodule

// File: rtl/guest_mem_rules.sv
module guest_mem_rules
   import priv_gate_pkg::*;
#(
   parameter int CTX_W      = 4,
   parameter int STAGE2_BIT = 3,
   parameter int SUM_IDX    = 2
) (
   input  logic [1:0]       priv_i,
   input  gate_ctl_t        ctl_i,
   input  logic             exec_i,
   input  logic             spvp_i,
   input  logic             vs_sum_i,
   output logic [1:0]       vd_o,
   output logic [CTX_W-1:0] ctx_o
);
   localparam int IDX_W = STAGE2_BIT;

   generate
      if (STAGE2_BIT >= CTX_W) begin : g_bad_flag
         $error("STAGE2_BIT must lie inside the context width");
      end
      if (SUM_IDX < 2 || SUM_IDX >= (1 << STAGE2_BIT)) begin : g_bad_sum
         $error("SUM_IDX must differ from the plain modes and fit below the flag");
      end
   endgenerate

   logic             is_u, is_m;
   logic [IDX_W-1:0] mode_idx;
   logic             use_sum;

   assign is_u = (priv_i == PL_USER);
   assign is_m = (priv_i == PL_MACH);

   always_comb begin
      if (is_m)                    vd_o = VD_ALLOW;
      else if (ctl_i.virt)         vd_o = VD_VIRTUAL;
      else if (is_u && !ctl_i.hu)  vd_o = VD_ILLEGAL;
      else                         vd_o = VD_ALLOW;
   end

   assign use_sum = !exec_i && spvp_i && vs_sum_i;

   always_comb begin
      if (use_sum) mode_idx = IDX_W'(SUM_IDX);
      else         mode_idx = IDX_W'(spvp_i);
   end

   generate
      if (STAGE2_BIT == CTX_W - 1) begin : g_flag_top
         assign ctx_o = {1'b1, mode_idx};
      end else begin : g_flag_mid
         assign ctx_o = {{(CTX_W-STAGE2_BIT-1){1'b0}}, 1'b1, mode_idx};
      end
   endgenerate

   always_comb begin
      if (!$isunknown({priv_i, ctl_i, exec_i, spvp_i, vs_sum_i})) begin
         assert_stage2_flag_R8: assert (ctx_o[STAGE2_BIT] == 1'b1)
            else $error("two-stage flag missing");
         if (exec_i)
            assert_exec_no_sum_R8: assert (ctx_o[IDX_W-1:0] == IDX_W'(spvp_i))
               else $error("execute-type access took the SUM index");
         if (is_m)
            assert_mach_allow_R7: assert (vd_o == VD_ALLOW)
               else $error("guest access faulted in machine mode");
      end
   end

endmodule

// File: rtl/priv_op_gate.sv
module priv_op_gate
   import priv_gate_pkg::*;
#(
   parameter int OP_W       = 3,
   parameter int VD_W       = 2,
   parameter int CTX_W      = 4,
   parameter int STAGE2_BIT = 3,
   parameter int SUM_IDX    = 2
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [1:0]       priv_i,
   input  logic             virt_i,
   input  logic             has_smode_i,
   input  logic             mst_tw_i,
   input  logic             mst_tvm_i,
   input  logic             hst_vtw_i,
   input  logic             hst_vtvm_i,
   input  logic             hst_hu_i,
   input  logic             hst_spvp_i,
   input  logic             vs_sum_i,
   output logic [VD_W-1:0]  verdict_o,
   output logic [CTX_W-1:0] ctx_o
);
   generate
      if (OP_W != 3) begin : g_bad_op
         $error("OP_W must be 3 to cover the eight instruction selectors");
      end
      if (VD_W != 2) begin : g_bad_vd
         $error("VD_W must be 2 for the verdict encoding");
      end
   endgenerate

   gate_ctl_t  ctl;
   logic [1:0] wait_vd, rsv_vd, sf_vd, hfv_vd, hfp_vd, gm_vd;
   logic [CTX_W-1:0] gm_ctx;
   logic       is_gmem;

   assign ctl = '{virt: virt_i, has_smode: has_smode_i, tw: mst_tw_i,
                  tvm: mst_tvm_i, vtw: hst_vtw_i, vtvm: hst_vtvm_i,
                  hu: hst_hu_i};

   wait_rules u_wait (
      .priv_i    (priv_i),
      .ctl_i     (ctl),
      .wait_vd_o (wait_vd),
      .rsv_vd_o  (rsv_vd)
   );

   fence_rules u_fence (
      .priv_i   (priv_i),
      .ctl_i    (ctl),
      .sf_vd_o  (sf_vd),
      .hfv_vd_o (hfv_vd),
      .hfp_vd_o (hfp_vd)
   );

   guest_mem_rules #(
      .CTX_W      (CTX_W),
      .STAGE2_BIT (STAGE2_BIT),
      .SUM_IDX    (SUM_IDX)
   ) u_gmem (
      .priv_i   (priv_i),
      .ctl_i    (ctl),
      .exec_i   (op_i == OP_G_XLOAD),
      .spvp_i   (hst_spvp_i),
      .vs_sum_i (vs_sum_i),
      .vd_o     (gm_vd),
      .ctx_o    (gm_ctx)
   );

   assign is_gmem = (op_i == OP_G_LOAD) || (op_i == OP_G_STORE) || (op_i == OP_G_XLOAD);

   always_comb begin
      case (op_i)
         OP_WAIT:     verdict_o = wait_vd;
         OP_RSV_WAIT: verdict_o = rsv_vd;
         OP_SFENCE:   verdict_o = sf_vd;
         OP_HF_GVIRT: verdict_o = hfv_vd;
         OP_HF_GPHYS: verdict_o = hfp_vd;
         default:     verdict_o = gm_vd;
      endcase
   end

   assign ctx_o = is_gmem ? gm_ctx : '0;

   always_comb begin
      if (!$isunknown({op_i, priv_i})) begin
         if (!is_gmem)
            assert_ctx_idle_R9: assert (ctx_o == '0)
               else $error("context driven for a non-guest instruction");
         assert_verdict_code_R2: assert (verdict_o != 2'd3)
            else $error("reserved verdict code");
      end
   end

endmodule

// File: tb/priv_op_gate_tb.sv
module priv_op_gate_tb;
   import priv_gate_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [2:0] op;
   logic [1:0] priv;
   logic virt, has_s, tw, tvm, vtw, vtvm, hu, spvp, vsum;
   logic [1:0] verdict;
   logic [3:0] ctx;

   int n_checks = 0;
   int n_fail   = 0;

   priv_op_gate u_dut (
      .op_i(op), .priv_i(priv), .virt_i(virt), .has_smode_i(has_s),
      .mst_tw_i(tw), .mst_tvm_i(tvm), .hst_vtw_i(vtw), .hst_vtvm_i(vtvm),
      .hst_hu_i(hu), .hst_spvp_i(spvp), .vs_sum_i(vsum),
      .verdict_o(verdict), .ctx_o(ctx)
   );

   typedef struct packed {
      logic [2:0] op;
      logic [1:0] priv;
      logic       virt, has_s, tw, tvm, vtw, vtvm, hu, spvp, vsum;
      logic [1:0] res;
      logic [3:0] ctx;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 42;
   // fields: op, priv, virt, has_s, tw, tvm, vtw, vtvm, hu, spvp, vsum, res, ctx, req
   localparam vec_t VEC [NV] = '{
      // R1 wait illegal
      '{3'd0,2'd1,0,1,1,0,0,0,0,0,0,2'd1,4'd0,4'd1},
      '{3'd0,2'd0,0,0,1,0,0,0,0,0,0,2'd1,4'd0,4'd1},
      '{3'd0,2'd0,0,0,0,0,0,0,0,0,0,2'd0,4'd0,4'd1},
      '{3'd0,2'd0,0,1,0,0,0,0,0,0,0,2'd1,4'd0,4'd1},
      '{3'd0,2'd3,0,1,1,0,0,0,0,0,0,2'd0,4'd0,4'd1},
      // R2 wait virtual
      '{3'd0,2'd0,1,1,0,0,0,0,0,0,0,2'd2,4'd0,4'd2},
      '{3'd0,2'd1,1,1,0,0,1,0,0,0,0,2'd2,4'd0,4'd2},
      '{3'd0,2'd1,1,1,0,0,0,0,0,0,0,2'd0,4'd0,4'd2},
      // R10 illegal beats virtual
      '{3'd0,2'd1,1,1,1,0,1,0,0,0,0,2'd1,4'd0,4'd10},
      // R3 reservation wait
      '{3'd1,2'd1,1,1,0,0,1,0,0,0,0,2'd2,4'd0,4'd3},
      '{3'd1,2'd0,1,1,1,0,1,0,0,0,0,2'd1,4'd0,4'd3},
      '{3'd1,2'd3,0,1,1,0,0,0,0,0,0,2'd0,4'd0,4'd3},
      '{3'd1,2'd0,0,1,0,0,0,0,0,0,0,2'd0,4'd0,4'd3},
      '{3'd1,2'd1,0,1,1,0,0,0,0,0,0,2'd1,4'd0,4'd3},
      // R4 supervisor fence
      '{3'd2,2'd0,0,1,0,0,0,0,0,0,0,2'd1,4'd0,4'd4},
      '{3'd2,2'd1,0,1,0,1,0,0,0,0,0,2'd1,4'd0,4'd4},
      '{3'd2,2'd1,0,1,0,0,0,0,0,0,0,2'd0,4'd0,4'd4},
      '{3'd2,2'd0,1,1,0,0,0,0,0,0,0,2'd2,4'd0,4'd4},
      '{3'd2,2'd1,1,1,0,0,0,1,0,0,0,2'd2,4'd0,4'd4},
      '{3'd2,2'd1,1,1,0,1,0,0,0,0,0,2'd0,4'd0,4'd4},
      '{3'd2,2'd3,0,1,0,1,0,0,0,0,0,2'd0,4'd0,4'd4},
      // R5 guest-virtual fence
      '{3'd3,2'd1,1,1,0,0,0,0,0,0,0,2'd2,4'd0,4'd5},
      '{3'd3,2'd0,1,1,0,0,0,0,0,0,0,2'd2,4'd0,4'd5},
      '{3'd3,2'd3,0,1,0,0,0,0,0,0,0,2'd0,4'd0,4'd5},
      '{3'd3,2'd1,0,1,0,1,0,0,0,0,0,2'd0,4'd0,4'd5},
      '{3'd3,2'd0,0,1,0,0,0,0,0,0,0,2'd1,4'd0,4'd5},
      // R6 guest-physical fence
      '{3'd4,2'd1,0,1,0,1,0,0,0,0,0,2'd1,4'd0,4'd6},
      '{3'd4,2'd1,0,1,0,0,0,0,0,0,0,2'd0,4'd0,4'd6},
      '{3'd4,2'd1,1,1,0,1,0,0,0,0,0,2'd2,4'd0,4'd6},
      '{3'd4,2'd0,0,1,0,0,0,0,0,0,0,2'd1,4'd0,4'd6},
      '{3'd4,2'd3,0,1,0,1,0,0,0,0,0,2'd0,4'd0,4'd6},
      // R7 guest memory verdicts
      '{3'd5,2'd3,0,1,0,0,0,0,0,0,0,2'd0,4'd8,4'd7},
      '{3'd5,2'd1,1,1,0,0,0,0,1,0,0,2'd2,4'd8,4'd7},
      '{3'd5,2'd0,0,1,0,0,0,0,0,0,0,2'd1,4'd8,4'd7},
      '{3'd5,2'd0,0,1,0,0,0,0,1,0,0,2'd0,4'd8,4'd7},
      '{3'd5,2'd1,0,1,0,0,0,0,0,0,0,2'd0,4'd8,4'd7},
      // R8 context index
      '{3'd5,2'd3,0,1,0,0,0,0,0,1,1,2'd0,4'd10,4'd8},
      '{3'd6,2'd3,0,1,0,0,0,0,0,1,0,2'd0,4'd9,4'd8},
      '{3'd7,2'd3,0,1,0,0,0,0,0,1,1,2'd0,4'd9,4'd8},
      '{3'd7,2'd3,0,1,0,0,0,0,0,0,1,2'd0,4'd8,4'd8},
      '{3'd6,2'd1,0,1,0,0,0,0,0,0,1,2'd0,4'd8,4'd8},
      '{3'd7,2'd0,0,1,0,0,0,0,0,1,1,2'd1,4'd9,4'd8}
   };

   task automatic check(input string tag, input logic [1:0] exp_res,
                        input logic [3:0] exp_ctx);
      n_checks++;
      if (verdict !== exp_res || ctx !== exp_ctx) begin
         n_fail++;
         $display("FAIL %s: op=%0d priv=%0d verdict=%0d ctx=%0d expected verdict=%0d ctx=%0d",
                  tag, op, priv, verdict, ctx, exp_res, exp_ctx);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      {op, priv} = {v.op, v.priv};
      {virt, has_s, tw, tvm, vtw, vtvm, hu, spvp, vsum} =
         {v.virt, v.has_s, v.tw, v.tvm, v.vtw, v.vtvm, v.hu, v.spvp, v.vsum};
      #5;
   endtask

   initial begin
      #4_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      op = 3'd0; priv = 2'd3;
      {virt, has_s, tw, tvm, vtw, vtvm, hu, spvp, vsum} = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #5;
      check("R1 reset state machine wait", 2'd0, 4'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].res, VEC[i].ctx);
      end

      // R9: every non-guest opcode with context-shaping inputs set
      for (int k = 0; k < 5; k++) begin
         apply('{3'(k),2'd3,0,1,0,0,0,0,1,1,1,2'd0,4'd0,4'd9});
         check("R9 context idle", 2'd0, 4'd0);
      end

      // R10: user mode without supervisor, virtualized, timeout-wait set
      apply('{3'd0,2'd0,1,0,1,0,0,0,0,0,0,2'd1,4'd0,4'd10});
      check("R10 user no-supervisor priority", 2'd1, 4'd0);

      // R3: virtual timeout-wait ignored once timeout-wait is set in supervisor
      apply('{3'd1,2'd1,1,1,1,0,1,0,0,0,0,2'd1,4'd0,4'd3});
      check("R3 timeout-wait masks virtual", 2'd1, 4'd0);

      // R7: machine mode with virtualization flag still allowed
      apply('{3'd6,2'd3,1,1,0,0,0,0,0,1,1,2'd0,4'd10,4'd7});
      check("R7 machine overrides virtual", 2'd0, 4'd10);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule